// File: doc/BRIEF.md
# Manchester Bi-Phase Word Decoder with Error Checks

This block receives the oversampled serial line of a 1 Mbps command/response bus whose words are Manchester bi-phase coded. It waits for the line to be quiet, locks its half-bit timing to the leading edge of a sync, and checks the sync. It then deserializes sixteen data bits and an odd parity bit, most significant bit first. Each half-bit level is decided by a majority vote over the samples taken in that half. The sync shape tells a command word from a data word.

One bit time after the parity bit, the block gives one report. A clean word comes out with a one-cycle valid strobe, together with the sync-type flag. A damaged word gives no valid strobe. Instead it raises one-cycle pulses on separate Manchester, parity and length error flags. A malformed sync is dropped without any report, and the block goes back to hunting for quiet line.

Top module: `mwd_word_decoder`

## Requirements
- R1: A command sync is three half-bit periods high followed by three low, and a data sync is three low followed by three high. Every report sets `is_command` to 1 after a command sync and to 0 after a data sync, and the flag holds until the next report.
- R2: Each data bit is two half-bit periods: high-then-low decodes as 1 and low-then-high decodes as 0. The first data bit after the sync becomes `word[15]`. A clean word appears on `word` with `word_valid` high for exactly one cycle.
- R3: A half-bit level is the majority of its SAMPLES_PER_BIT/2 samples. A single sample flipped inside a half-bit period does not change the decoded word.
- R4: A bit whose two halves are equal (both high or both low) raises `err_manchester` in that word's report.
- R5: Odd parity is used: across the 16 data bits and the parity bit (the first half of the 17th bit pair) the count of ones must be odd. Otherwise `err_parity` is raised, so 7C12h needs a parity bit of 0.
- R6: Three or more equal consecutive half-bit periods inside the data and parity region mean bits are missing, and raise `err_length`. A frame that ends before its parity bit raises both `err_length` and `err_manchester`.
- R7: A level change between the two half-bit periods that follow the parity bit means extra bits, and raises `err_length`.
- R8: A word with any error produces no `word_valid`. Error flags are one-cycle pulses, and `word` changes only together with `word_valid`, so it keeps the last clean word.
- R9: A sync that does not match either shape produces no valid strobe and no error flag.
- R10: A sync leading edge is accepted only after 1.5 bit times (3 half-bit periods) with no level change. A frame that follows another burst with no such gap is not decoded. A gapped frame after it is decoded normally.
- R11: The report appears 42 half-bit periods plus 3 clock cycles after the clock cycle in which the sync's leading edge is placed on the line.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, SAMPLES_PER_BIT cycles per bus bit |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial bus line |
| word | output | 16 | Last clean decoded word |
| word_valid | output | 1 | One-cycle strobe for a clean word |
| is_command | output | 1 | Sync type of the latest report (1 = command) |
| err_manchester | output | 1 | One-cycle pulse: a bit had equal halves |
| err_parity | output | 1 | One-cycle pulse: odd parity failed |
| err_length | output | 1 | One-cycle pulse: missing or extra bits |

## Verification
A wrong half-bit counter or a misplaced lock point shows up at the ports as a report that comes one or more cycles off its expected slot, or as a wrong word. The bench compares every output on every clock, so such a fault is caught within one cycle of the report. A stale error accumulator or a wrong parity register shows as a spurious or missing flag pulse on the very next word. A re-arm fault shows as an unexpected report during a burst that should have been ignored.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,   // waiting for a quiet line
    ST_ARMED,  // quiet seen, next edge opens a frame
    ST_SYNC,   // checking the six sync half-bits
    ST_DATA,   // capturing data and parity half-bits
    ST_GUARD   // watching one bit time after parity, then reporting
  } ctrl_st_e;

  localparam int SYNC_HALVES  = 6;
  localparam int GUARD_HALVES = 2;
endpackage

// File: rtl/mwd_line_sync.sv
module mwd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic edge_seen
);
  logic [STAGES-1:0] pipe;
  logic              lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= '0;
      lvl_d <= 1'b0;
    end else begin
      pipe  <= {pipe[STAGES-2:0], line_in};
      lvl_d <= pipe[STAGES-1];
    end
  end

  assign lvl       = pipe[STAGES-1];
  assign edge_seen = lvl ^ lvl_d;
endmodule

// File: rtl/mwd_half_slicer.sv
module mwd_half_slicer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic lvl,
  output logic half_vld,
  output logic half_val
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] sidx;
  logic [CW-1:0] ones;
  logic [CW-1:0] ones_n;

  assign ones_n = ones + CW'(lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sidx     <= '0;
      ones     <= '0;
      half_vld <= 1'b0;
      half_val <= 1'b0;
    end else if (restart) begin
      // the edge sample is sample 0 of the first half-bit
      sidx     <= CW'(1);
      ones     <= CW'(lvl);
      half_vld <= 1'b0;
    end else begin
      half_vld <= 1'b0;
      if (sidx == CW'(HALF - 1)) begin
        half_vld <= 1'b1;
        half_val <= (ones_n > CW'(HALF / 2));
        sidx     <= '0;
        ones     <= '0;
      end else begin
        sidx <= sidx + CW'(1);
        ones <= ones_n;
      end
    end
  end

  // R3: one vote per half-bit period, never on back-to-back cycles
  p_half_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    half_vld |=> !half_vld);
endmodule

// File: rtl/mwd_frame_ctrl.sv
module mwd_frame_ctrl
  import mwd_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int HALF        = 4,
  parameter int IDLE_HALVES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lvl,
  input  logic                 edge_seen,
  input  logic                 half_vld,
  input  logic                 half_val,
  output logic                 restart,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 cmd_o,
  output logic                 man_err_o,
  output logic                 par_err_o,
  output logic                 len_err_o
);
  localparam int LAST_DATA = SYNC_HALVES + 2 * (WORD_BITS + 1) - 1;
  localparam int GUARD0    = LAST_DATA + 1;
  localparam int TOTAL     = GUARD0 + GUARD_HALVES;
  localparam int HW        = $clog2(TOTAL);
  localparam int IDLE_CYC  = IDLE_HALVES * HALF;
  localparam int IW        = $clog2(IDLE_CYC + 1);

  ctrl_st_e         st;
  logic [IW-1:0]    idle_cnt;
  logic [HW-1:0]    hidx;
  logic             lead, first_h, prev_h, pair_run, man_acc, len_acc;
  logic [WORD_BITS:0] shreg;
  logic             exp_sync, len_fin, par_bad;

  assign restart  = (st == ST_ARMED) && edge_seen;
  assign exp_sync = (hidx < HW'(SYNC_HALVES / 2)) ? lead : ~lead;
  assign len_fin  = len_acc | (half_val != first_h);
  assign par_bad  = ~(^shreg);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      idle_cnt  <= '0;
      hidx      <= '0;
      lead      <= 1'b0;
      first_h   <= 1'b0;
      prev_h    <= 1'b0;
      pair_run  <= 1'b0;
      man_acc   <= 1'b0;
      len_acc   <= 1'b0;
      shreg     <= '0;
      word_o    <= '0;
      valid_o   <= 1'b0;
      cmd_o     <= 1'b0;
      man_err_o <= 1'b0;
      par_err_o <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      man_err_o <= 1'b0;
      par_err_o <= 1'b0;
      len_err_o <= 1'b0;
      case (st)
        ST_HUNT: begin
          if (edge_seen) idle_cnt <= '0;
          else if (idle_cnt == IW'(IDLE_CYC - 1)) begin
            st       <= ST_ARMED;
            idle_cnt <= '0;
          end else idle_cnt <= idle_cnt + IW'(1);
        end
        ST_ARMED: begin
          if (edge_seen) begin
            st      <= ST_SYNC;
            lead    <= lvl;
            hidx    <= '0;
            man_acc <= 1'b0;
            len_acc <= 1'b0;
          end
        end
        ST_SYNC: begin
          if (half_vld) begin
            if (half_val != exp_sync) begin
              st       <= ST_HUNT;  // malformed sync: drop silently
              idle_cnt <= '0;
            end else begin
              hidx <= hidx + HW'(1);
              if (hidx == HW'(SYNC_HALVES - 1)) st <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (half_vld) begin
            hidx   <= hidx + HW'(1);
            prev_h <= half_val;
            if (hidx == HW'(SYNC_HALVES)) pair_run <= 1'b0;
            else if (half_val == prev_h) begin
              if (pair_run) len_acc <= 1'b1;
              pair_run <= 1'b1;
            end else pair_run <= 1'b0;
            if (!hidx[0]) first_h <= half_val;
            else begin
              shreg <= {shreg[WORD_BITS-1:0], first_h};
              if (half_val == first_h) man_acc <= 1'b1;
            end
            if (hidx == HW'(LAST_DATA)) st <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (half_vld) begin
            if (hidx == HW'(GUARD0)) begin
              first_h <= half_val;
              hidx    <= hidx + HW'(1);
            end else begin
              valid_o   <= ~(man_acc | len_fin | par_bad);
              if (~(man_acc | len_fin | par_bad)) word_o <= shreg[WORD_BITS:1];
              cmd_o     <= lead;
              man_err_o <= man_acc;
              par_err_o <= par_bad;
              len_err_o <= len_fin;
              st        <= ST_HUNT;
              idle_cnt  <= '0;
            end
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  // R8: a clean strobe never coincides with an error flag
  p_valid_clean_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !(man_err_o || par_err_o || len_err_o));
  // R8: strobes last one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R8: the word only moves with a clean strobe
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (word_o != $past(word_o)) |-> valid_o);
  // R10: arming only follows a cycle with no line change
  p_arm_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED && $past(st) == ST_HUNT) |-> !$past(edge_seen));
  // R11: every report closes the guard window
  p_report_slot_r11: assert property (@(posedge clk) disable iff (rst)
    (valid_o || man_err_o || par_err_o || len_err_o) |-> $past(st) == ST_GUARD);
endmodule

// File: rtl/mwd_word_decoder.sv
module mwd_word_decoder #(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int WORD_BITS       = 16,
  parameter int SYNC_STAGES     = 2,
  parameter int IDLE_HALVES     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_in,
  output logic [WORD_BITS-1:0] word,
  output logic                 word_valid,
  output logic                 is_command,
  output logic                 err_manchester,
  output logic                 err_parity,
  output logic                 err_length
);
  localparam int HALF = SAMPLES_PER_BIT / 2;

  logic lvl, edge_seen, restart, half_vld, half_val;

  mwd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(line_in), .lvl(lvl), .edge_seen(edge_seen)
  );

  mwd_half_slicer #(.HALF(HALF)) u_slicer (
    .clk(clk), .rst(rst), .restart(restart), .lvl(lvl),
    .half_vld(half_vld), .half_val(half_val)
  );

  mwd_frame_ctrl #(
    .WORD_BITS(WORD_BITS), .HALF(HALF), .IDLE_HALVES(IDLE_HALVES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .lvl(lvl), .edge_seen(edge_seen),
    .half_vld(half_vld), .half_val(half_val), .restart(restart),
    .word_o(word), .valid_o(word_valid), .cmd_o(is_command),
    .man_err_o(err_manchester), .par_err_o(err_parity), .len_err_o(err_length)
  );
endmodule

// File: tb/tb_mwd_word_decoder.sv
module tb_mwd_word_decoder;
  localparam int SPB = 8;
  localparam int H   = SPB / 2;

  typedef struct {
    int          at;
    bit          v;
    logic [15:0] w;
    bit          c, me, pe, le;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic [15:0] word;
  logic word_valid, is_command, err_manchester, err_parity, err_length;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  exp_t exp_q[$];
  logic [15:0] m_word = '0;
  bit m_cmd = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mwd_word_decoder #(.SAMPLES_PER_BIT(SPB)) dut (
    .clk(clk), .rst(rst), .line_in(line), .word(word), .word_valid(word_valid),
    .is_command(is_command), .err_manchester(err_manchester),
    .err_parity(err_parity), .err_length(err_length)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (chk_on) begin
      exp_t e;
      if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
        e = exp_q.pop_front();
        chk(1'b0, {e.tag, " report missing"}, 32'(cyc), 32'(e.at));
      end
      if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        e = exp_q.pop_front();
        chk({word_valid, err_manchester, err_parity, err_length} == {e.v, e.me, e.pe, e.le},
            {e.tag, " R11 flags"},
            32'({word_valid, err_manchester, err_parity, err_length}),
            32'({e.v, e.me, e.pe, e.le}));
        if (e.v) m_word = e.w;
        m_cmd = e.c;
      end else begin
        chk({word_valid, err_manchester, err_parity, err_length} == 4'b0, "R8 R9 no report",
            32'({word_valid, err_manchester, err_parity, err_length}), 32'h0);
      end
      chk(word === m_word, "R2 R8 word", 32'(word), 32'(m_word));
      chk(is_command === m_cmd, "R1 sync type", 32'(is_command), 32'(m_cmd));
    end
  end

  function automatic void build(output bit hv[42], input bit lead, input logic [15:0] d);
    bit p;
    p = ~(^d);
    for (int i = 0; i < 3; i++) begin hv[i] = lead; hv[i+3] = ~lead; end
    for (int b = 0; b < 16; b++) begin hv[6+2*b] = d[15-b]; hv[7+2*b] = ~d[15-b]; end
    hv[38] = p; hv[39] = ~p;
    hv[40] = hv[39]; hv[41] = hv[39];
  endfunction

  // behavioural reference of one frame
  task automatic model(input bit hv[42], input bit lead, input int at, input string tag,
                       output bit ok, output exp_t e);
    bit [16:0] bits;
    int run;
    ok = 1'b1;
    for (int i = 0; i < 3; i++) if (hv[i] != lead || hv[i+3] == lead) ok = 1'b0;
    e.at = at; e.c = lead; e.me = 0; e.pe = 0; e.le = 0; e.tag = tag;
    for (int b = 0; b < 17; b++) begin
      bits[16-b] = hv[6+2*b];
      if (hv[6+2*b] == hv[7+2*b]) e.me = 1;
    end
    run = 1;
    for (int i = 7; i < 40; i++) begin
      if (hv[i] == hv[i-1]) run++; else run = 1;
      if (run >= 3) e.le = 1;
    end
    if (hv[40] != hv[41]) e.le = 1;
    e.pe = ($countones(bits) % 2) == 0;
    e.w = bits[16:1];
    e.v = !(e.me || e.pe || e.le);
  endtask

  task automatic drive_level(input bit v, input int n);
    repeat (n) begin @(negedge clk); line = v; end
  endtask

  task automatic drive_halves(input bit hv[42], input int n, input int gh, input int gs, output int t0);
    t0 = 0;
    for (int h = 0; h < n; h++)
      for (int s = 0; s < H; s++) begin
        @(negedge clk);
        if (h == 0 && s == 0) t0 = cyc;
        line = hv[h] ^ ((h == gh) && (s == gs));
      end
  endtask

  // mode: 0 clean, 1 equal halves, 2 parity flip, 3 truncated, 4 extra bits, 5 glitch, 6 bad sync
  task automatic run_word(input bit lead, input logic [15:0] d, input int mode, input string tag);
    bit hv[42];
    int t0, gh;
    bit ok;
    exp_t e;
    build(hv, lead, d);
    gh = -1;
    case (mode)
      1: hv[13] = hv[12];
      2: begin hv[38] = ~hv[38]; hv[39] = ~hv[39]; end
      3: begin hv[38] = hv[37]; hv[39] = hv[37]; end
      5: gh = 10;
      6: hv[4] = lead;
      default: ;
    endcase
    hv[40] = hv[39]; hv[41] = hv[39];
    if (mode == 4) hv[40] = ~hv[39];
    drive_level(~lead, 10 * H);
    drive_halves(hv, 42, gh, 2, t0);
    model(hv, lead, t0 + 3 + 42 * H, tag, ok, e);
    if (ok) exp_q.push_back(e);
    drive_level(hv[41], 2 * H);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit hb[42], hg[42];
    int t0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk({word, word_valid, is_command, err_manchester, err_parity, err_length} == '0,
        "R12 reset outputs", 32'({word, word_valid, is_command}), 32'h0);
    chk_on = 1'b1;

    run_word(1'b1, 16'h38A4, 0, "R1 R2 command");
    run_word(1'b0, 16'h7C12, 0, "R5 data word parity 0");
    run_word(1'b0, 16'hA5A5, 0, "R2 data");
    run_word(1'b1, 16'hFFFF, 0, "R2 all ones");
    run_word(1'b0, 16'h0000, 0, "R2 all zeros");
    run_word(1'b1, 16'h1234, 5, "R3 glitch");
    run_word(1'b0, 16'h0F0F, 1, "R4 equal halves");
    run_word(1'b0, 16'h7C12, 2, "R5 parity flip");
    run_word(1'b1, 16'h95A4, 3, "R6 truncated");
    run_word(1'b0, 16'h3B06, 4, "R7 extra bits");
    run_word(1'b1, 16'hFA0E, 6, "R9 bad sync");
    run_word(1'b1, 16'h3A84, 0, "R8 recover");

    // R10: a frame glued to a preceding burst is not decoded
    drive_level(1'b0, 10 * H);
    build(hb, 1'b1, 16'h8001);
    hb[4] = 1'b1;
    build(hg, 1'b1, 16'h8000);
    drive_halves(hb, 40, -1, 0, t0);
    drive_halves(hg, 42, -1, 0, t0);
    drive_level(hg[41], 2 * H);
    run_word(1'b0, 16'h5A5A, 0, "R10 rearm");

    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R11 pending reports", 32'(exp_q.size()), 32'h0);
    finish_up();
  end
endmodule